// File: doc/BRIEF.md
# Non-Restoring Division Step Unit with Unsigned Sequencer

The block holds a one-bit non-restoring division step and a small controller that drives it to form an unsigned quotient. Each step takes a partial remainder, a divisor and three status bits (a quotient-sign flag Q, a divisor-sign flag M and a carry-style flag T). It shifts the remainder left with T entering at the bottom. It then adds or subtracts the divisor and produces a new remainder, a new Q and a new T, all in one cycle. The T flag carries the quotient bit out of the step.

The controller accepts a start pulse with a dividend and a divisor and clears Q, M and T. It holds the dividend in a quotient shift register. On each of WIDTH step cycles, the top bit of that register feeds the step's T input, and the previous T moves into the register's bottom bit. One final cycle shifts in the last T. The controller then presents the quotient with a one-cycle done pulse. Signed operands, remainder correction and a zero divisor are not handled.

Top module: `nrdiv_top`

## Requirements
- R1: After reset, busy and done are 0 and quotient is 0.
- R2: A start seen while busy is 0 is accepted; busy is 1 from the next cycle until the edge that raises done.
- R3: done is 1 for exactly one cycle. It rises at the WIDTH+1-th rising edge after the edge that accepted start.
- R4: For a nonzero divisor, the quotient shown while done is 1 equals floor(dividend / divisor), both operands unsigned.
- R5: While busy is 1, start and any change on dividend or divisor are ignored. The result and its timing come from the operands captured at acceptance.
- R6: After done, quotient holds its value until the next accepted start.
- R7: Each step subtracts the divisor from the shifted remainder when the previous Q equals M, and adds it otherwise. With M at 0, the remainder read as a signed value with Q as its sign stays within [-divisor, divisor).
- R8: After each step, the new Q equals the shifted-out remainder MSB XOR M XOR the carry (for an add) or the borrow (for a subtract). T is 1 exactly when the new Q equals M.
- R9: The captured divisor is not modified while a division runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled when idle |
| dividend | input | WIDTH | Unsigned dividend |
| divisor | input | WIDTH | Unsigned divisor, nonzero |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result strobe |
| quotient | output | WIDTH | Unsigned quotient |

## Verification
The bench builds two copies of the block. A 6-bit copy is swept over every dividend and every nonzero divisor, which covers every remainder-sign path of the step and every quotient-bit pattern of that width. A 32-bit copy at the default width runs dividends 0, 1 and all-ones plus random values against random and edge divisors (1, all-ones, MSB only). Some of its runs pulse start and change the operands mid-division, and all of them check the done timing and that the quotient holds afterwards.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  // strobes from the controller to the datapath
  typedef struct packed {
    logic load;    // capture operands, clear flags
    logic step;    // perform one division step
    logic finish;  // shift the last quotient bit in
  } seqStrobes_t;
endpackage

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] remIn,
  input  logic [WIDTH-1:0] dvsIn,
  input  logic             qIn,
  input  logic             mIn,
  input  logic             tIn,
  output logic [WIDTH-1:0] remOut,
  output logic             qOut,
  output logic             tOut
);
  logic             topBit;
  logic [WIDTH-1:0] shifted;
  logic             doSub;
  logic [WIDTH:0]   wideRes;

  always_comb begin
    topBit  = remIn[WIDTH-1];
    shifted = {remIn[WIDTH-2:0], tIn};
    doSub   = (qIn == mIn);
    if (doSub) wideRes = {1'b0, shifted} - {1'b0, dvsIn};
    else       wideRes = {1'b0, shifted} + {1'b0, dvsIn};
    remOut = wideRes[WIDTH-1:0];
    qOut   = topBit ^ mIn ^ wideRes[WIDTH];
    tOut   = (qOut == mIn);
  end
endmodule

// File: rtl/nrdiv_dpath.sv
module nrdiv_dpath
  import nrdiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      strobes,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient
);
  logic [WIDTH-1:0] remReg;
  logic [WIDTH-1:0] quoReg;
  logic [WIDTH-1:0] dvsReg;
  logic             qFlag, mFlag, tFlag;
  logic [WIDTH-1:0] nextRem;
  logic             nextQ, nextT;

  nrdiv_step #(.WIDTH(WIDTH)) step_i (
    .remIn (remReg),
    .dvsIn (dvsReg),
    .qIn   (qFlag),
    .mIn   (mFlag),
    .tIn   (quoReg[WIDTH-1]),
    .remOut(nextRem),
    .qOut  (nextQ),
    .tOut  (nextT)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg <= '0;
      quoReg <= '0;
      dvsReg <= '0;
      qFlag  <= 1'b0;
      mFlag  <= 1'b0;
      tFlag  <= 1'b0;
    end else if (strobes.load) begin
      remReg <= '0;
      quoReg <= dividend;
      dvsReg <= divisor;
      qFlag  <= 1'b0;
      mFlag  <= 1'b0;
      tFlag  <= 1'b0;
    end else if (strobes.step) begin
      remReg <= nextRem;
      quoReg <= {quoReg[WIDTH-2:0], tFlag};
      qFlag  <= nextQ;
      tFlag  <= nextT;
    end else if (strobes.finish) begin
      quoReg <= {quoReg[WIDTH-2:0], tFlag};
    end
  end

  assign quotient = quoReg;

  // remainder viewed as signed with Q as sign bit
  logic signed [WIDTH+1:0] remVal, dvsVal;
  assign remVal = {qFlag, qFlag, remReg};
  assign dvsVal = {2'b00, dvsReg};

  p_rem_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && dvsReg != '0) |=> (remVal < dvsVal) && (remVal >= -dvsVal));

  p_t_tracks_q_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (tFlag == (qFlag == mFlag)));

  p_divisor_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(dvsReg));

  p_quo_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> $stable(quoReg));

  p_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));
endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output seqStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} seqState_t;
  seqState_t state;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strobes        = '0;
    strobes.load   = (state == S_IDLE) && start;
    strobes.step   = (state == S_RUN);
    strobes.finish = (state == S_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state   <= S_RUN;
          stepCnt <= '0;
        end
        S_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CNT_W'(WIDTH - 1)) state <= S_FIN;
        end
        S_FIN: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

  // cycle counter for timing check
  logic [CNT_W:0] elapsed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              elapsed <= '0;
    else if (strobes.load)  elapsed <= '0;
    else if (busy)          elapsed <= elapsed + 1'b1;
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_timing_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (elapsed == (CNT_W+1)'(WIDTH + 1)));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |-> !strobes.load);

  p_idle_on_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/nrdiv_top.sv
module nrdiv_top
  import nrdiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient
);
  seqStrobes_t strobes;

  nrdiv_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobes(strobes),
    .busy   (busy),
    .done   (done)
  );

  nrdiv_dpath #(.WIDTH(WIDTH)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dividend(dividend),
    .divisor (divisor),
    .quotient(quotient)
  );
endmodule

// File: tb/nrdiv_top_tb_top.sv
`timescale 1ns/1ps
module nrdiv_top_tb_top;
  localparam int WB = 32;
  localparam int WS = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          startB = 1'b0, startS = 1'b0;
  logic [WB-1:0] dvdB = '0, dvsB = '0, quoB;
  logic [WS-1:0] dvdS = '0, dvsS = '0, quoS;
  logic          busyB, doneB, busyS, doneS;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  nrdiv_top #(.WIDTH(WB)) dut_i (
    .clk(clk), .rstN(rstN), .start(startB), .dividend(dvdB), .divisor(dvsB),
    .busy(busyB), .done(doneB), .quotient(quoB));

  nrdiv_top #(.WIDTH(WS)) dut_w6_i (
    .clk(clk), .rstN(rstN), .start(startS), .dividend(dvdS), .divisor(dvsS),
    .busy(busyS), .done(doneS), .quotient(quoS));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 32-bit run; disturb pulses start and alters operands mid-run (R5)
  task automatic runBig(input logic [WB-1:0] a, input logic [WB-1:0] b, input bit disturb);
    int k;
    logic [WB-1:0] expQ;
    expQ = a / b;
    @(negedge clk);
    dvdB = a; dvsB = b; startB = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      startB = 1'b0;
      if (k == 1) check("R2 busy after start", 64'(busyB), 64'd1);
      if (disturb && k == 3) begin
        startB = 1'b1; dvdB = ~a; dvsB = b ^ 32'h5A5A_0001;
      end
      if (disturb && k == 4) startB = 1'b0;
    end while (!doneB && k < WB + 10);
    check("R3 done timing", 64'(k), 64'(WB + 2));
    check(disturb ? "R5 ignored mid-run" : "R4 quotient", 64'(quoB), 64'(expQ));
    @(negedge clk);
    check("R3 done one cycle", 64'(doneB), 64'd0);
    dvdB = ~dvdB; dvsB = dvsB + 1;
    repeat (2) @(negedge clk);
    check("R6 quotient held", 64'(quoB), 64'(expQ));
  endtask

  task automatic runSmall(input logic [WS-1:0] a, input logic [WS-1:0] b);
    int k;
    @(negedge clk);
    dvdS = a; dvsS = b; startS = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      startS = 1'b0;
    end while (!doneS && k < WS + 10);
    if (k != WS + 2) check("R3 done timing w6", 64'(k), 64'(WS + 2));
    check("R4 quotient w6 sweep", 64'(quoS), 64'(a / b));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [WB-1:0] dvsList[8];
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy reset", 64'(busyB), 64'd0);
    check("R1 done reset", 64'(doneB), 64'd0);
    check("R1 quotient reset", 64'(quoB), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 64'(busyS), 64'd0);

    // exhaustive small sweep (R4, R7, R8)
    for (int a = 0; a < (1 << WS); a++)
      for (int b = 1; b < (1 << WS); b++)
        runSmall(WS'(a), WS'(b));

    // big-width directed and random
    dvsList[0] = 32'd1;
    dvsList[1] = 32'hFFFF_FFFF;
    dvsList[2] = 32'h8000_0000;
    dvsList[3] = 32'd3;
    for (int i = 4; i < 8; i++) dvsList[i] = $urandom | 32'd1;
    for (int i = 0; i < 8; i++) begin
      runBig(32'd0, dvsList[i], 1'b0);
      runBig(32'd1, dvsList[i], 1'b0);
      runBig(32'hFFFF_FFFF, dvsList[i], 1'b0);
    end
    for (int i = 0; i < 24; i++) begin
      logic [WB-1:0] b;
      b = $urandom >> ($urandom % 31);
      if (b == 0) b = 32'd7;
      runBig($urandom, b, 1'b0);
      runBig(32'hFFFF_FFFF, b, 1'b0);
    end
    // R5 and R9: operands and start disturbed while busy
    for (int i = 0; i < 6; i++) begin
      logic [WB-1:0] b;
      b = ($urandom >> (i * 4)) | 32'd1;
      runBig($urandom, b, 1'b1);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule